// File: doc/BRIEF.md
# Region Wait-State Generator

This block sits beside a bus master and converts each memory request into a stall length. The request supplies an address, an access width (16 or 32 bits) and a flag saying whether it continues a sequential run. From the address it picks one of sixteen regions, looks up the wait cycles for that region and width, and then holds a busy indication for the stall before issuing a one-cycle ready strobe. A request may instead describe a burst of consecutive 32-bit accesses. In that case the block charges one first access followed by sequential accesses and stalls for the whole burst as a single operation.

A 16-bit control word sets the timing of three external memory windows and of one battery-backed RAM window. Each external window has a first-access code and a sequential-access code. Each window also answers at a second, mirror region. The 32-bit timings are derived arithmetically from the 16-bit ones. One region has fixed default timing, and every other region costs nothing. A control bit enables prefetch: while it is set, the prefetch wait reported for the external windows drops to zero. The block does not contain a prefetch buffer or any memory arrays.

Top module: `bus_wait_gen`

## Requirements
- R1: After a synchronous reset, busy, ready, wait_cnt, pf_wait and prefetch_en are 0. The control word is 0, so a 16-bit first access to region 8 costs 4 waits.
- R2: The region is req_addr[27:24]. Region 2 costs 2 waits for a 16-bit access and 4 waits for a 32-bit access, whether or not the access is sequential. Regions 0, 1, 3 to 7 and 15 cost 0 waits.
- R3: The first-access codes sit in control bits [3:2] for window 0 (regions 8 and 9), bits [6:5] for window 1 (regions 10 and 11) and bits [9:8] for window 2 (regions 12 and 13). Codes 0, 1, 2 and 3 give 4, 3, 2 and 8 waits for a 16-bit non-sequential access. A mirror region has the same timing as its base region.
- R4: The sequential codes sit in control bit 4 (window 0), bit 7 (window 1) and bit 10 (window 2). A code of 1 gives 1 wait for a 16-bit sequential access. A code of 0 gives 2, 4 or 8 waits for window 0, 1 or 2.
- R5: For regions 8 to 13, a 32-bit non-sequential wait is first16 + 1 + seq16, and a 32-bit sequential wait is 2*seq16 + 1.
- R6: Region 14 (battery RAM) takes its wait from control bits [1:0], with the same 4/3/2/8 mapping for both sequential and first accesses. Its 32-bit wait is 2*w + 1.
- R7: A burst request with count N (a count of 0 is treated as 1) ignores req_wide and req_seq. It costs (1 + first32) + (N-1)*(1 + seq32) waits for the region.
- R8: A request is accepted on a clock edge where req_valid=1 and busy=0. From the following cycle, wait_cnt holds the count W and busy is 1 for W+1 cycles. Ready is then high for exactly one cycle, with busy 0.
- R9: A request presented while busy is 1 is ignored. The stall in progress keeps its wait_cnt, pf_wait and ready timing.
- R10: A control write changes only accesses accepted after the write edge. A request accepted on the same edge uses the old control word. A stall already running keeps its count.
- R11: prefetch_en follows control bit 14 from the cycle after the write. pf_wait is latched with wait_cnt and equals the sequential wait of the access width. For regions 8 to 13 it is 0 instead when prefetch is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request address; bits [27:24] select the region |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| req_seq | input | 1 | 1 = sequential access |
| req_burst | input | 1 | 1 = burst of 32-bit accesses |
| req_count | input | CNT_W | Number of accesses in a burst |
| busy | output | 1 | Stall in progress |
| ready | output | 1 | One-cycle completion strobe |
| wait_cnt | output | WAIT_W | Wait count latched for the current stall |
| pf_wait | output | 5 | Prefetch wait latched for the current stall |
| prefetch_en | output | 1 | Prefetch enable from the control word |

## Verification
A control-word write and the acceptance of a request can land on the same clock edge. A write can also arrive in the middle of a stall. The bench provokes the first case by raising cfg_we together with req_valid, and judges the result by comparing the latched count with a model that still holds the old control word. It then sends a follow-up access, which must show the new timing. For the second case the bench writes a random control word during a stall and requires wait_cnt to stay constant and ready to arrive on the originally predicted cycle. A request presented during a stall is handled the same way: the running stall must carry on unchanged.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
  localparam int SLOT_W     = 5;
  localparam int NUM_WIN    = 3;
  localparam int WIN_BASE   = 8;
  localparam int BATT_REGION = 14;
  localparam int FIXED_REGION = 2;
  localparam int FIXED_W16  = 2;
  localparam int FIXED_W32  = 4;
  localparam int PF_BIT     = 14;

  typedef struct packed {
    logic [SLOT_W-1:0] n16;
    logic [SLOT_W-1:0] s16;
    logic [SLOT_W-1:0] n32;
    logic [SLOT_W-1:0] s32;
  } wait_set_t;

  function automatic logic [SLOT_W-1:0] first_wait(input logic [1:0] code);
    case (code)
      2'd0: first_wait = SLOT_W'(4);
      2'd1: first_wait = SLOT_W'(3);
      2'd2: first_wait = SLOT_W'(2);
      default: first_wait = SLOT_W'(8);
    endcase
  endfunction

  // Slow sequential wait doubles per window: 2, 4, 8.
  function automatic logic [SLOT_W-1:0] seq_wait(input int win, input logic code);
    seq_wait = code ? SLOT_W'(1) : SLOT_W'(2 << win);
  endfunction

  function automatic wait_set_t derive_set(input logic [SLOT_W-1:0] n16,
                                           input logic [SLOT_W-1:0] s16);
    wait_set_t r;
    r.n16 = n16;
    r.s16 = s16;
    r.n32 = n16 + s16 + SLOT_W'(1);
    r.s32 = {s16[SLOT_W-2:0], 1'b1};
    return r;
  endfunction
endpackage

// File: rtl/bwg_cfg_reg.sv
module bwg_cfg_reg
  import bwg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [15:0] wdata,
  output wait_set_t   win_sets [NUM_WIN],
  output wait_set_t   batt_set,
  output logic        pf_en
);
  logic [15:0] ctl_q;

  always_ff @(posedge clk) begin
    if (rst)     ctl_q <= '0;
    else if (we) ctl_q <= wdata;
  end

  assign pf_en = ctl_q[PF_BIT];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    localparam int FIRST_LSB = 2 + 3 * g;
    localparam int SEQ_BIT   = 4 + 3 * g;
    assign win_sets[g] = derive_set(first_wait(ctl_q[FIRST_LSB +: 2]),
                                    seq_wait(g, ctl_q[SEQ_BIT]));
  end

  always_comb begin
    logic [SLOT_W-1:0] bw;
    bw = first_wait(ctl_q[1:0]);
    batt_set.n16 = bw;
    batt_set.s16 = bw;
    batt_set.n32 = {bw[SLOT_W-2:0], 1'b1};
    batt_set.s32 = {bw[SLOT_W-2:0], 1'b1};
  end
endmodule

// File: rtl/bwg_region_lut.sv
module bwg_region_lut
  import bwg_pkg::*;
#(
  parameter int REGION_W = 4
) (
  input  logic [REGION_W-1:0] region,
  input  wait_set_t           win_sets [NUM_WIN],
  input  wait_set_t           batt_set,
  output wait_set_t           sel_set,
  output logic                is_win
);
  localparam int WIN_LAST = WIN_BASE + 2 * NUM_WIN - 1;

  always_comb begin
    int r;
    r = int'(region);
    sel_set = '0;
    is_win  = 1'b0;
    if (r == FIXED_REGION) begin
      sel_set.n16 = SLOT_W'(FIXED_W16);
      sel_set.s16 = SLOT_W'(FIXED_W16);
      sel_set.n32 = SLOT_W'(FIXED_W32);
      sel_set.s32 = SLOT_W'(FIXED_W32);
    end else if (r >= WIN_BASE && r <= WIN_LAST) begin
      // Base region and its mirror share a window.
      sel_set = win_sets[(r - WIN_BASE) >> 1];
      is_win  = 1'b1;
    end else if (r == BATT_REGION) begin
      sel_set = batt_set;
    end
  end
endmodule

// File: rtl/bwg_stall_ctr.sv
module bwg_stall_ctr #(
  parameter int WAIT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WAIT_W-1:0] load_val,
  output logic              busy,
  output logic              ready
);
  logic [WAIT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      ready    <= 1'b0;
      remain_q <= '0;
    end else begin
      ready <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          remain_q <= load_val;
        end
      end else if (remain_q != '0) begin
        remain_q <= remain_q - WAIT_W'(1);
      end else begin
        busy  <= 1'b0;
        ready <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
  import bwg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 24,
  parameter int REGION_W   = 4,
  parameter int CNT_W      = 5,
  parameter int WAIT_W     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wide,
  input  logic              req_seq,
  input  logic              req_burst,
  input  logic [CNT_W-1:0]  req_count,
  output logic              busy,
  output logic              ready,
  output logic [WAIT_W-1:0] wait_cnt,
  output logic [SLOT_W-1:0] pf_wait,
  output logic              prefetch_en
);
  wait_set_t win_sets [NUM_WIN];
  wait_set_t batt_set;
  wait_set_t sel_set;
  logic      is_win;
  logic      accept;
  logic [WAIT_W-1:0] wait_nxt;
  logic [SLOT_W-1:0] pf_nxt;

  bwg_cfg_reg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .win_sets (win_sets),
    .batt_set (batt_set),
    .pf_en    (prefetch_en)
  );

  bwg_region_lut #(.REGION_W(REGION_W)) u_lut (
    .region   (req_addr[REGION_LSB +: REGION_W]),
    .win_sets (win_sets),
    .batt_set (batt_set),
    .sel_set  (sel_set),
    .is_win   (is_win)
  );

  assign accept = req_valid && !busy;

  always_comb begin
    logic [WAIT_W-1:0] n_acc;
    n_acc = (req_count == '0) ? WAIT_W'(1) : WAIT_W'(req_count);
    if (req_burst) begin
      wait_nxt = WAIT_W'(sel_set.n32) + WAIT_W'(1)
               + (n_acc - WAIT_W'(1)) * (WAIT_W'(sel_set.s32) + WAIT_W'(1));
    end else if (req_wide) begin
      wait_nxt = WAIT_W'(req_seq ? sel_set.s32 : sel_set.n32);
    end else begin
      wait_nxt = WAIT_W'(req_seq ? sel_set.s16 : sel_set.n16);
    end
    if (is_win && prefetch_en) pf_nxt = '0;
    else pf_nxt = (req_wide || req_burst) ? sel_set.s32 : sel_set.s16;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_cnt <= '0;
      pf_wait  <= '0;
    end else if (accept) begin
      wait_cnt <= wait_nxt;
      pf_wait  <= pf_nxt;
    end
  end

  bwg_stall_ctr #(.WAIT_W(WAIT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .load_val (wait_nxt),
    .busy     (busy),
    .ready    (ready)
  );
endmodule

// File: rtl/bwg_checker.sv
module bwg_checker #(
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 24,
  parameter int WAIT_W     = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [15:0]       cfg_wdata,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_wide,
  input logic              req_burst,
  input logic              busy,
  input logic              ready,
  input logic [WAIT_W-1:0] wait_cnt,
  input logic [4:0]        pf_wait,
  input logic              prefetch_en
);
  assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (rst)
    ready |-> !busy);

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);

  assert_hold_count_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(wait_cnt) && $stable(pf_wait)));

  assert_pf_bit_R11: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (prefetch_en == $past(cfg_wdata[14])));

  assert_fixed_region_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && !req_burst && !req_wide
     && req_addr[REGION_LSB +: 4] == 4'd2) |=> (wait_cnt == WAIT_W'(2)));
endmodule

bind bus_wait_gen bwg_checker #(
  .ADDR_W(ADDR_W), .REGION_LSB(REGION_LSB), .WAIT_W(WAIT_W)
) u_bwg_checker (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .req_valid(req_valid), .req_addr(req_addr), .req_wide(req_wide),
  .req_burst(req_burst), .busy(busy), .ready(ready), .wait_cnt(wait_cnt),
  .pf_wait(pf_wait), .prefetch_en(prefetch_en)
);

// File: tb/test_bus_wait_gen.sv
module test_bus_wait_gen;
  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_we = 0;
  logic [15:0] cfg_wdata = 0;
  logic        req_valid = 0;
  logic [31:0] req_addr = 0;
  logic        req_wide = 0, req_seq = 0, req_burst = 0;
  logic [4:0]  req_count = 0;
  logic        busy, ready, prefetch_en;
  logic [11:0] wait_cnt;
  logic [4:0]  pf_wait;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] cfg_model = 0;

  always #10 clk = ~clk;

  bus_wait_gen i_bus_wait_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_wide(req_wide),
    .req_seq(req_seq), .req_burst(req_burst), .req_count(req_count),
    .busy(busy), .ready(ready), .wait_cnt(wait_cnt), .pf_wait(pf_wait),
    .prefetch_en(prefetch_en)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int first_of(input logic [1:0] c);
    case (c)
      2'd0: return 4;
      2'd1: return 3;
      2'd2: return 2;
      default: return 8;
    endcase
  endfunction

  // Model: {n16, s16, n32, s32, is_window}
  function automatic void region_waits(input logic [15:0] c, input int r,
      output int n16, output int s16, output int n32, output int s32, output bit win);
    n16 = 0; s16 = 0; n32 = 0; s32 = 0; win = 0;
    if (r == 2) begin n16 = 2; s16 = 2; n32 = 4; s32 = 4; end
    else if (r >= 8 && r <= 13) begin
      int w;
      w = (r - 8) / 2;
      win = 1;
      n16 = first_of(c[2 + 3*w +: 2]);
      s16 = c[4 + 3*w] ? 1 : (2 << w);
      n32 = n16 + 1 + s16;
      s32 = 2 * s16 + 1;
    end else if (r == 14) begin
      n16 = first_of(c[1:0]); s16 = n16; n32 = 2*n16 + 1; s32 = n32;
    end
  endfunction

  function automatic int exp_wait(input logic [15:0] c, input logic [31:0] a,
      input bit wide, input bit seq, input bit burst, input int cnt);
    int n16, s16, n32, s32, n; bit win;
    region_waits(c, int'(a[27:24]), n16, s16, n32, s32, win);
    if (burst) begin
      n = (cnt == 0) ? 1 : cnt;
      return (1 + n32) + (n - 1) * (1 + s32);
    end
    if (wide) return seq ? s32 : n32;
    return seq ? s16 : n16;
  endfunction

  function automatic int exp_pf(input logic [15:0] c, input logic [31:0] a,
      input bit wide, input bit burst);
    int n16, s16, n32, s32; bit win;
    region_waits(c, int'(a[27:24]), n16, s16, n32, s32, win);
    if (win && c[14]) return 0;
    return (wide || burst) ? s32 : s16;
  endfunction

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
    cfg_model = v;
    check("R11 prefetch_en", int'(prefetch_en), int'(v[14]));
  endtask

  // mode: 0 plain, 1 request during stall, 2 cfg write during stall,
  //       3 cfg write on acceptance edge
  task automatic run_access(input logic [31:0] a, input bit wide, input bit seq,
      input bit burst, input int cnt, input int mode, input logic [15:0] v,
      input string tag);
    int w, p;
    w = exp_wait(cfg_model, a, wide, seq, burst, cnt);
    p = exp_pf(cfg_model, a, wide, burst);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_wide = wide; req_seq = seq;
    req_burst = burst; req_count = 5'(cnt);
    if (mode == 3) begin cfg_we = 1; cfg_wdata = v; end
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    if (mode == 3) cfg_model = v;
    check({tag, " busy after accept"}, int'(busy), 1);
    check({tag, " wait_cnt"}, int'(wait_cnt), w);
    check({tag, " pf_wait"}, int'(pf_wait), p);
    for (int j = 0; j < w; j++) begin
      if (j == 0 && mode == 1) begin
        req_valid = 1; req_addr = 32'h0C00_0000; req_burst = 1; req_count = 5'd31;
      end
      if (j == 0 && mode == 2) begin cfg_we = 1; cfg_wdata = v; end
      @(negedge clk);
      req_valid = 0; req_burst = 0; cfg_we = 0;
      if (j == 0 && mode == 2) cfg_model = v;
      if (busy !== 1'b1 || ready !== 1'b0 || wait_cnt != 12'(w)) begin
        check({tag, " stall hold (R9)"}, int'(wait_cnt), w);
        check({tag, " busy during stall (R8)"}, int'(busy), 1);
      end
    end
    @(negedge clk);
    check({tag, " ready strobe (R8)"}, int'(ready), 1);
    check({tag, " idle at ready (R8)"}, int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 ready", int'(ready), 0);
    check("R1 wait_cnt", int'(wait_cnt), 0);
    check("R1 pf_wait", int'(pf_wait), 0);
    check("R1 prefetch_en", int'(prefetch_en), 0);
    run_access(32'h0800_0010, 0, 0, 0, 0, 0, 0, "R1");

    // R2 fixed and empty regions
    run_access(32'h0200_0000, 0, 0, 0, 0, 0, 0, "R2");
    run_access(32'h0200_0004, 1, 1, 0, 0, 0, 0, "R2");
    run_access(32'h0500_0000, 1, 0, 0, 0, 0, 0, "R2");
    run_access(32'h0F00_0000, 0, 0, 0, 0, 0, 0, "R2");
    run_access(32'h0000_0000, 1, 1, 0, 0, 0, 0, "R2");

    // R3 first-access codes and mirrors
    write_cfg(16'h0344);
    run_access(32'h0900_0000, 0, 0, 0, 0, 0, 0, "R3");
    run_access(32'h0A00_0000, 0, 0, 0, 0, 0, 0, "R3");
    run_access(32'h0D00_0000, 0, 0, 0, 0, 0, 0, "R3");

    // R4 sequential codes
    write_cfg(16'h0000);
    run_access(32'h0800_0000, 0, 1, 0, 0, 0, 0, "R4");
    run_access(32'h0B00_0000, 0, 1, 0, 0, 0, 0, "R4");
    run_access(32'h0C00_0000, 0, 1, 0, 0, 0, 0, "R4");
    write_cfg(16'h0490);
    run_access(32'h0C00_0000, 0, 1, 0, 0, 0, 0, "R4");

    // R5 32-bit derivation
    write_cfg(16'h0000);
    run_access(32'h0C00_0000, 1, 0, 0, 0, 0, 0, "R5");
    run_access(32'h0D00_0000, 1, 1, 0, 0, 0, 0, "R5");

    // R6 battery window
    write_cfg(16'h0003);
    run_access(32'h0E00_0000, 0, 0, 0, 0, 0, 0, "R6");
    run_access(32'h0E00_0000, 1, 1, 0, 0, 0, 0, "R6");

    // R7 bursts
    write_cfg(16'h0000);
    run_access(32'h0800_0000, 0, 0, 1, 4, 0, 0, "R7");
    run_access(32'h0800_0000, 0, 1, 1, 0, 0, 0, "R7");
    run_access(32'h0800_0000, 0, 0, 1, 1, 0, 0, "R7");
    run_access(32'h0C00_0000, 0, 0, 1, 31, 0, 0, "R7");

    // R9 request during stall; R10 write mid-stall and on accept edge
    run_access(32'h0A00_0000, 0, 0, 0, 0, 1, 0, "R9");
    run_access(32'h0C00_0000, 1, 0, 0, 0, 2, 16'h4FFF, "R10");
    run_access(32'h0C00_0000, 1, 0, 0, 0, 0, 0, "R10 new cfg");
    run_access(32'h0800_0000, 0, 0, 0, 0, 3, 16'h000C, "R10");
    run_access(32'h0800_0000, 0, 0, 0, 0, 0, 0, "R10 after");

    // R11 prefetch
    write_cfg(16'h4000);
    run_access(32'h0800_0000, 0, 0, 0, 0, 0, 0, "R11");
    run_access(32'h0200_0000, 0, 0, 0, 0, 0, 0, "R11");
    run_access(32'h0E00_0000, 1, 0, 0, 0, 0, 0, "R11");

    // Constrained random traffic
    for (int i = 0; i < 250; i++) begin
      logic [31:0] a;
      bit b;
      int md;
      if ($urandom_range(0, 7) == 0) write_cfg(16'($urandom));
      a = $urandom;
      a[27:24] = 4'($urandom_range(0, 15));
      b = ($urandom_range(0, 3) == 0);
      md = $urandom_range(0, 3);
      run_access(a, 1'($urandom), 1'($urandom), b, $urandom_range(0, 31),
                 md, 16'($urandom), "R8 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule